// File: doc/BRIEF.md
# Write Protect Register Logic

This block guards the program path of a 2K x 8 nonvolatile array. Every program request that reaches it carries a target address and, when the target is the protection register, a data byte. One clock later the block answers with a single allow/deny flag. Array locations are gated by a software write-enable latch and by a two-bit block-lock field. The protection register itself is gated by the arming rules and by a sticky hardware lock that only takes effect while the external protect pin is high.

The register sits at the highest address of a 12-bit request space (0xFFF). Array cells occupy 0x000 to 0x7FF; the gap 0x800 to 0xFFE holds nothing and is always refused. The register contents are shown on an output at all times. The arming state is a two-state machine. ST_DISARMED is the reset state. It moves to ST_ARMED on an accepted arming write (T_ARM). From ST_ARMED it moves back to ST_DISARMED when an accepted register write clears the latch bit (T_DISARM). Every other accepted or refused write keeps the current state (T_HOLD). The hardware lock is not a state. It is the condition "pin high and enable bit set", evaluated on every request.

Top module: `wp_guard`

## Requirements
- R1: Request address 0xFFF selects the protection register, 0x000..0x7FF select array cells, and any request to 0x800..0xFFE is refused.
- R2: An array request is refused whenever the write-enable latch (register bit 1) is clear.
- R3: Block-lock field, register bits 4:3, fences the array: 00 fences nothing, 01 fences 0x600..0x7FF, 10 fences 0x400..0x7FF, 11 fences 0x000..0x7FF. An armed request to an unfenced array cell is allowed; a request to a fenced cell is refused.
- R4: In ST_DISARMED, a register write with data exactly 0x02 is allowed and sets only the latch. Any other data is refused and leaves the register unchanged.
- R5: In ST_ARMED, an allowed register write loads bits 7, 4, 3 and 1 from the data byte. Writing 0x00 clears every field and returns to ST_DISARMED.
- R6: With the protect pin high and hardware-lock enable (register bit 7) set, every register write is refused and the register holds. Array requests still follow R2 and R3.
- R7: With the protect pin low, bit 7 has no effect, and the register stays writable under R4 and R5, which includes clearing bit 7.
- R8: Register bits 6, 5, 2 and 0 always read zero, whatever data was written.
- R9: The response appears one cycle after the request, with resp_valid high. In a cycle after no request, resp_valid and resp_allow are both low.
- R10: Reset clears the register to 0x00 and the responses to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A program request is presented this cycle |
| req_addr | input | 12 | Target address (0xFFF = protection register) |
| req_wdata | input | 8 | Data byte, used when the register is the target |
| prot_pin | input | 1 | Hardware protect pin |
| resp_valid | output | 1 | Registered: a decision is presented |
| resp_allow | output | 1 | Registered: the request was allowed |
| prot_reg | output | 8 | Current register contents |

## Verification
The embedded properties check several rules on every cycle:
- A disarmed array request is never allowed.
- A full lock refuses every array cell.
- Out-of-range addresses are refused.
- A frozen register, or one hit by an illegal disarmed write, holds its value.
- An idle cycle leaves both response flags low.

Only the bench's scenarios can show the rest: the exact fence boundaries for each lock code, the field loading by armed writes, the masking of reserved bits, and the effect of toggling the pin to release and reapply the hardware lock.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int REG_W    = 8;
    localparam int WEL_BIT  = 1;
    localparam int BLK_LO   = 3;
    localparam int HWEN_BIT = 7;
    localparam logic [REG_W-1:0] ARM_PATTERN = 8'h02;

    typedef enum logic [0:0] {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic       hw_en;
        logic [1:0] blk;
    } prot_fields_t;

    function automatic logic [REG_W-1:0] pack_reg(prot_fields_t f, logic wel);
        logic [REG_W-1:0] r;
        r                      = '0;
        r[HWEN_BIT]            = f.hw_en;
        r[BLK_LO+1:BLK_LO]     = f.blk;
        r[WEL_BIT]             = wel;
        return r;
    endfunction

endpackage

// File: rtl/wp_region_check.sv
module wp_region_check #(
    parameter int AW = 11
) (
    input  logic [AW:0]  addr,
    input  logic [1:0]   blk,
    output logic         is_reg,
    output logic         in_array,
    output logic         blk_hit
);
    localparam int NCODES = 4;
    localparam logic [AW:0] LO_NONE = (AW+1)'(1) << AW;
    localparam logic [AW:0] LO_QTR  = (AW+1)'(3) << (AW-2);
    localparam logic [AW:0] LO_HALF = (AW+1)'(1) << (AW-1);
    localparam logic [AW:0] LO_ALL  = '0;

    logic [AW:0] lo_tab [NCODES];

    for (genvar k = 0; k < NCODES; k++) begin : g_bound
        if (k == 0) begin : g_none
            assign lo_tab[k] = LO_NONE;
        end else if (k == 1) begin : g_qtr
            assign lo_tab[k] = LO_QTR;
        end else if (k == 2) begin : g_half
            assign lo_tab[k] = LO_HALF;
        end else begin : g_all
            assign lo_tab[k] = LO_ALL;
        end
    end

    always_comb begin
        is_reg   = &addr;
        in_array = ~addr[AW];
        blk_hit  = in_array && (addr >= lo_tab[blk]);
    end

endmodule

// File: rtl/wp_arm_fsm.sv
module wp_arm_fsm
    import wp_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reg,
    input  logic [REG_W-1:0]  wdata,
    input  logic              pin,
    output logic              wel,
    output prot_fields_t      fields,
    output logic              accept
);
    arm_state_e   state_q, state_d;
    prot_fields_t fields_q, fields_d;
    logic         frozen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_DISARMED;
            fields_q <= '0;
        end else begin
            state_q  <= state_d;
            fields_q <= fields_d;
        end
    end

    always_comb begin
        frozen   = pin && fields_q.hw_en;
        accept   = 1'b0;
        state_d  = state_q;
        fields_d = fields_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (wr_reg && !frozen && (wdata == ARM_PATTERN)) begin
                    accept  = 1'b1;
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (wr_reg && !frozen) begin
                    accept         = 1'b1;
                    fields_d.hw_en = wdata[HWEN_BIT];
                    fields_d.blk   = wdata[BLK_LO+1:BLK_LO];
                    state_d        = wdata[WEL_BIT] ? ST_ARMED : ST_DISARMED;
                end
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    always_comb begin
        wel    = (state_q == ST_ARMED);
        fields = fields_q;
    end

    // R6: a frozen register holds through any write attempt
    a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && pin && fields_q.hw_en) |=> ($stable(state_q) && $stable(fields_q)));

    // R4: a disarmed write other than the arming pattern changes nothing
    a_r4_illegal_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && state_q == ST_DISARMED && wdata != ARM_PATTERN)
            |=> ($stable(state_q) && $stable(fields_q)));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW:0]       req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic              prot_pin,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic [REG_W-1:0]  prot_reg
);
    logic         is_reg, in_array, blk_hit;
    logic         wel, reg_accept, allow_d;
    prot_fields_t fields;
    logic         resp_valid_q, resp_allow_q;

    wp_region_check #(.AW(AW)) u_region (
        .addr     (req_addr),
        .blk      (fields.blk),
        .is_reg   (is_reg),
        .in_array (in_array),
        .blk_hit  (blk_hit)
    );

    wp_arm_fsm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_reg (req_valid && is_reg),
        .wdata  (req_wdata),
        .pin    (prot_pin),
        .wel    (wel),
        .fields (fields),
        .accept (reg_accept)
    );

    always_comb begin
        if (is_reg) allow_d = reg_accept;
        else        allow_d = in_array && wel && !blk_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_allow_q <= 1'b0;
        end else begin
            resp_valid_q <= req_valid;
            resp_allow_q <= req_valid && allow_d;
        end
    end

    always_comb begin
        resp_valid = resp_valid_q;
        resp_allow = resp_allow_q;
        prot_reg   = pack_reg(fields, wel);
    end

    // R2: no array write passes while the latch is clear
    a_r2_disarmed_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_reg && !wel) |=> !resp_allow);

    // R3: full lock refuses every array cell
    a_r3_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_reg && fields.blk == 2'b11) |=> !resp_allow);

    // R1: the hole between array and register is never writable
    a_r1_hole_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_reg && req_addr[AW]) |=> !resp_allow);

    // R9: idle cycle yields no response
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_allow));

endmodule

// File: tb/wp_guard_bench.sv
module wp_guard_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        prot_pin = 1'b0;
    logic        resp_valid, resp_allow;
    logic [7:0]  prot_reg;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural reference state
    int m_wel = 0, m_blk = 0, m_hw = 0;
    int e_valid = 0, e_allow = 0;

    always #(PERIOD/2) clk = ~clk;

    wp_guard u_wp_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .prot_pin(prot_pin), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .prot_reg(prot_reg)
    );

    function automatic int exp_reg();
        return (m_hw << 7) | (m_blk << 3) | (m_wel << 1);
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (resp_valid !== 1'(e_valid) || resp_allow !== 1'(e_allow) || prot_reg !== 8'(exp_reg())) begin
            miscompares++;
            $display("FAIL %s: got valid=%0d allow=%0d reg=%02h, expected valid=%0d allow=%0d reg=%02h",
                     tag, resp_valid, resp_allow, prot_reg, e_valid, e_allow, exp_reg());
        end
    endtask

    task automatic model(input bit v, input int a, input int d, input bit p);
        int lo;
        e_valid = v;
        e_allow = 0;
        if (!v) return;
        if (a == 'hFFF) begin
            if (p && m_hw) e_allow = 0;
            else if (!m_wel) begin
                e_allow = (d == 'h02);
                if (e_allow) m_wel = 1;
            end else begin
                e_allow = 1;
                m_hw  = (d >> 7) & 1;
                m_blk = (d >> 3) & 3;
                m_wel = (d >> 1) & 1;
            end
        end else if (a >= 'h800) begin
            e_allow = 0;
        end else begin
            lo = (m_blk == 0) ? 'h800 : (m_blk == 1) ? 'h600 : (m_blk == 2) ? 'h400 : 0;
            e_allow = m_wel && (a < lo);
        end
    endtask

    task automatic step(input bit v, input int a, input int d, input bit p, input string tag);
        req_valid = v;
        req_addr  = 12'(a);
        req_wdata = 8'(d);
        prot_pin  = p;
        @(posedge clk);
        model(v, a, d, p);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R10 reset state");
        rst_n = 1'b1;
        step(0, 0, 0, 0, "R9 idle after reset");
        step(1, 'h010, 0, 0, "R2 disarmed array write");
        step(1, 'hFFF, 'h9A, 0, "R4 illegal disarmed reg write");
        step(1, 'hFFF, 'h03, 0, "R4 near-pattern refused");
        step(1, 'hFFF, 'h02, 0, "R4 arming write");
        step(1, 'h010, 0, 0, "R2 armed array write");
        step(1, 'h900, 0, 0, "R1 hole address");
        step(1, 'hFFE, 0, 0, "R1 top of hole");
        step(1, 'h7FF, 0, 0, "R1 last array cell");
        step(1, 'hFFF, 'h0A, 0, "R5 load quarter lock");
        step(1, 'h5FF, 0, 0, "R3 below quarter fence");
        step(1, 'h600, 0, 0, "R3 quarter fence edge");
        step(1, 'hFFF, 'h12, 0, "R5 load half lock");
        step(1, 'h3FF, 0, 0, "R3 below half fence");
        step(1, 'h400, 0, 0, "R3 half fence edge");
        step(1, 'hFFF, 'h1A, 0, "R5 load full lock");
        step(1, 'h000, 0, 0, "R3 full lock bottom");
        step(1, 'hFFF, 'hFF, 0, "R8 reserved bits masked");
        step(1, 'hFFF, 'h02, 1, "R6 frozen reg write");
        step(1, 'hFFF, 'h82, 1, "R6 frozen reg write 2");
        step(1, 'h000, 0, 1, "R6 array under full lock");
        step(0, 0, 0, 1, "R9 idle with pin high");
        step(1, 'hFFF, 'h82, 0, "R7 pin low reg write");
        step(1, 'h100, 0, 1, "R6 array allowed while frozen");
        step(1, 'hFFF, 'h00, 1, "R6 frozen clear attempt");
        step(1, 'hFFF, 'h00, 0, "R7 clear with pin low");
        step(1, 'h100, 0, 0, "R5 disarmed after clear");
        step(1, 'hFFF, 'h82, 0, "R4 disarmed hw-enable refused");
        for (int i = 0; i < 64; i++) begin
            int code = i % 4;
            if (i % 16 == 0) step(1, 'hFFF, 'h02, 0, "R4 rearm");
            step(1, 'hFFF, (code << 3) | 'h02, 0, "R5 sweep lock load");
            step(1, (i * 37) & 'h7FF, 0, i & 1, "R3 sweep array");
            step(i % 3 == 0, 'h7C0 + i, 0, 0, "R9 sweep valid toggle");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule